// File: doc/BRIEF.md
# Edge-Flag Interrupt Status Register

This block watches six single-bit level sources, three comparator outputs and three battery-monitor valid signals. It keeps one sticky request flag per source. A source that changes level in either direction sets its flag. Software reads the flags over a byte-wide bus and clears chosen flags by writing zeros. An enable vector, which comes from outside the block, masks each flag onto a per-source request line. A single combined interrupt output is the OR of those request lines.

Every source passes through a two-flop synchronizer. An edge is a difference between the newest synchronized sample and the one stored a cycle earlier. A small sequencer has two named states. In `ST_PRIME`, which is entered at reset, the stored samples follow the synchronizer and no edge is reported. The transition `prime_done` fires after `SYNC_DEPTH+1` cycles and moves the sequencer to `ST_ARMED`, where edges are reported. `ST_ARMED` holds until the next reset. This keeps a source that is already high at reset from raising a false flag.

A clearing write acts only on flags that read as 1 on the most recent read. Each write uses up that read snapshot. An event that arrives between the read and the write is therefore kept. When a new edge and a clear land in the same cycle, the edge wins.

Top module: `edge_irq_status`

## Requirements
- R1: While reset is held and just after it, `rd_data` is 0x00, `irq_vec` is 0 and `irq` is 0.
- R2: Bit 3+i of the register is the flag of `cmp_in[i]` (bits 5:3). Bit i is the flag of `bat_valid[i]` (bits 2:0).
- R3: A level change on a source, rising or falling, sets its flag. The flag is visible at the third rising clock edge after the change and not before. No other flag is touched.
- R4: A write (`wr_en`=1) with a 0 in bit k clears flag k, provided flag k read as 1 on the last read (`rd_en`=1) before that write.
- R5: A write with a 1 in a flag bit leaves that flag unchanged.
- R6: A write with a 0 in bit k leaves flag k set if flag k read as 0 on the last read. An event arriving after the read is therefore kept.
- R7: If a flag's source edge is registered in the same cycle as a clearing write to that flag, the flag stays 1.
- R8: Bits 7:6 always read 0, and the values written to them have no effect.
- R9: `irq_vec[k]` is flag k AND `irq_en[k]`, and `irq` is the OR of `irq_vec`. Both are combinational from the flags.
- R10: Sources held at 1 through reset raise no flag. Edge reporting starts after the `ST_PRIME` interval.
- R11: A write uses up the read snapshot. A second clearing write with no read in between does not clear a flag that was set again after the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 3 | Comparator output levels, asynchronous |
| bat_valid | input | 3 | Battery-monitor valid levels, asynchronous |
| irq_en | input | 6 | Per-flag interrupt enable |
| rd_en | input | 1 | Read strobe; captures the read snapshot |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; a 0 requests a clear |
| rd_data | output | 8 | Register read value, flags in bits 5:0 |
| irq_vec | output | 6 | Per-flag interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume two things. First, `rd_en` and `wr_en` are never both high. Second, a source holds each level for at least three clock cycles, so every change passes the synchronizer as one clean edge. The stimulus drives the strobes one at a time. It changes sources only on falling clock edges and then waits three full cycles. The sweeps cover every per-source direction, every write mask and every pairing of flag pattern with enable pattern.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/edge_irq_seq.sv
module edge_irq_seq
    import edge_irq_pkg::*;
#(
    parameter int PRIME_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic arm
);
    localparam int CW = $clog2(PRIME_CYC + 1);

    arm_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic prime_done;

    assign prime_done = (cnt_q == CW'(PRIME_CYC - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (prime_done) state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PRIME && !prime_done) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        arm = (state_q == ST_ARMED);
    end

    p_armed_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm) |-> arm);
endmodule

// File: rtl/edge_irq_sync_edge.sv
module edge_irq_sync_edge #(
    parameter int N_SRC      = 6,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [N_SRC-1:0] src,
    output logic [N_SRC-1:0] edge_hit
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic [SYNC_DEPTH-1:0] chain_q;
        logic                  prev_q;
        logic                  samp;

        assign samp = chain_q[SYNC_DEPTH-1];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[SYNC_DEPTH-2:0], src[i]};
                prev_q  <= samp;
            end
        end

        assign edge_hit[i] = arm & (samp ^ prev_q);
    end
endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags #(
    parameter int N_SRC = 6,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] edge_hit,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [N_SRC-1:0] flags
);
    logic [N_SRC-1:0] flag_q, seen_q, clr_mask;

    assign clr_mask = wr_en ? (~wr_data[N_SRC-1:0] & seen_q) : '0;
    assign flags    = flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            seen_q <= '0;
        end else begin
            flag_q <= edge_hit | (flag_q & ~clr_mask);
            if (rd_en)      seen_q <= flag_q;
            else if (wr_en) seen_q <= '0;
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        p_rise_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(edge_hit[i]));
        p_write_one_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_en && wr_data[i] && flag_q[i]) |-> flag_q[i]);
        p_fall_needs_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[i]) |-> $past(wr_en && !wr_data[i] && seen_q[i]));
        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $past(edge_hit[i]) |-> flag_q[i]);
    end
endmodule

// File: rtl/edge_irq_status.sv
module edge_irq_status #(
    parameter int N_CMP      = 3,
    parameter int N_BAT      = 3,
    parameter int SYNC_DEPTH = 2,
    parameter int REG_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CMP-1:0]       cmp_in,
    input  logic [N_BAT-1:0]       bat_valid,
    input  logic [N_CMP+N_BAT-1:0] irq_en,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output logic [REG_W-1:0]       rd_data,
    output logic [N_CMP+N_BAT-1:0] irq_vec,
    output logic                   irq
);
    localparam int N_SRC     = N_CMP + N_BAT;
    localparam int PRIME_CYC = SYNC_DEPTH + 1;
    localparam int PAD_W     = REG_W - N_SRC;

    logic             arm;
    logic [N_SRC-1:0] src, edge_hit, flags;

    assign src = {cmp_in, bat_valid};

    edge_irq_seq #(.PRIME_CYC(PRIME_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .arm(arm)
    );

    edge_irq_sync_edge #(.N_SRC(N_SRC), .SYNC_DEPTH(SYNC_DEPTH)) u_edge (
        .clk(clk), .rst_n(rst_n), .arm(arm), .src(src), .edge_hit(edge_hit)
    );

    edge_irq_flags #(.N_SRC(N_SRC), .REG_W(REG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .flags(flags)
    );

    assign rd_data = {{PAD_W{1'b0}}, flags};
    assign irq_vec = flags & irq_en;
    assign irq     = |irq_vec;

    p_prime_no_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> (flags == '0));
endmodule

// File: tb/edge_irq_status_bench.sv
module edge_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmp_in = '0;
    logic [2:0] bat_valid = '0;
    logic [5:0] irq_en = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] irq_vec;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edge_irq_status u_edge_irq_status (
        .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .bat_valid(bat_valid),
        .irq_en(irq_en), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_vec(irq_vec), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic toggle(input logic [5:0] m);
        {cmp_in, bat_valid} = {cmp_in, bat_valid} ^ m;
    endtask

    task automatic clear_all();
        do_read();
        do_write(8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10: sources high through reset
        cmp_in = 3'b111;
        bat_valid = 3'b111;
        irq_en = 6'h3f;
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h00);
        check("R1 reset irq_vec", irq_vec, 6'h00);
        check("R1 reset irq", irq, 1'b0);
        tick(3);
        rst_n = 1'b1;
        tick(10);
        check("R10 no spurious flag", rd_data, 8'h00);
        check("R10 no spurious irq", irq, 1'b0);

        // R3/R2: each source, both directions, latency
        for (int i = 0; i < 6; i++) begin
            for (int dir = 0; dir < 2; dir++) begin
                clear_all();
                toggle(6'(1) << i);
                tick(2);
                check("R3 not before third edge", rd_data, 8'h00);
                tick(1);
                check("R2 R3 flag position", rd_data, 32'(1) << i);
            end
        end

        // R4/R5/R8: all flags set, sweep every write value
        for (int w = 0; w < 256; w++) begin
            clear_all();
            toggle(6'h3f);
            tick(3);
            check("R3 all set", rd_data, 8'h3f);
            do_read();
            do_write(8'(w));
            check("R4 R5 R8 after write", rd_data, 32'(w & 8'h3f));
        end

        // R6: event after read survives clear
        clear_all();
        toggle(6'h01);
        tick(3);
        do_read();
        toggle(6'h02);
        tick(3);
        do_write(8'h00);
        check("R6 unseen flag kept", rd_data, 8'h02);

        // R11: snapshot consumed by write
        clear_all();
        toggle(6'h04);
        tick(3);
        do_read();
        do_write(8'h00);
        check("R4 cleared", rd_data, 8'h00);
        toggle(6'h04);
        tick(3);
        do_write(8'h00);
        check("R11 second write no clear", rd_data, 8'h04);

        // R7: edge coincides with clearing write
        clear_all();
        toggle(6'h20);
        tick(3);
        do_read();
        toggle(6'h20);
        tick(2);
        do_write(8'h00);
        check("R7 set wins", rd_data, 8'h20);

        // R9: sweep flag patterns against enable patterns
        for (int p = 0; p < 64; p++) begin
            clear_all();
            toggle(6'(p));
            tick(3);
            check("R3 pattern", rd_data, 32'(p));
            for (int e = 0; e < 64; e++) begin
                irq_en = 6'(e);
                #1;
                check("R9 irq_vec", irq_vec, 32'(p & e));
                check("R9 irq", irq, 32'((p & e) != 0));
            end
        end

        finish_run();
    end
endmodule